// File: doc/BRIEF.md
# Shared-Entry Error Exception Detector

This block sits beside the issue stage of a processor pipeline and looks at every issued instruction for four error conditions: arithmetic range overflow, a memory access through a null address register, a stack frame that grows up to or past its upper bound, and a privileged operation run where privilege is lacking. Any one of these, or several at once, raises one exception request toward a single shared vector. The request is registered and lasts one cycle per offending instruction.

A null pointer access also blocks the memory access in the issue cycle, through a suppress output. The address-register update that goes with post-increment and next-address modes is not blocked, so the write-back enable is a function of the access mode alone. A coincident exception of higher priority cancels the request, and reset outranks everything.

The issue interface carries one instruction per cycle under a valid qualifier. The block never applies back-pressure: it has no ready output, and an instruction presented with valid high is evaluated in that cycle. The outputs are plain control pins.

Top module: `err_trap_detect`

## Requirements
- R1: While reset is active and in the first cycle after release with no valid instruction, the exception request is low.
- R2: A valid instruction with the overflow flag set raises the exception request in the following cycle for exactly one cycle.
- R3: A valid memory access whose address register reads zero drives the memory suppress output high in the same cycle and raises the exception request in the next cycle; a non-zero address leaves suppress low.
- R4: The address write-back enable is high in the issue cycle of a valid memory access exactly when the access mode is 2'b01 (post-increment) or 2'b10 (next address), whether or not the address is zero; modes 2'b00 and 2'b11 give no write-back.
- R5: A valid frame instruction raises the request when its new frame top is at or above the stack upper bound under an unsigned compare: equal values trigger, one below does not, and 0x8000_0000 against a bound of 0x7FFF_FFFF triggers.
- R6: A valid privileged operation raises the request when the current state is user, or when it is a return whose target state is user; in supervisor state without a return to user it does not.
- R7: Several error conditions on one instruction produce one request cycle, the same as a single condition.
- R8: When the higher-priority exception input is high in the issue cycle, no request is raised for that instruction, while suppress and write-back keep their values.
- R9: With valid low, all error inputs are ignored: suppress, write-back and the next-cycle request stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_ovf | input | 1 | Operand or result overflowed its range |
| iss_mem | input | 1 | Instruction performs a memory access |
| iss_addr | input | DW | Address register value used for the access |
| iss_amode | input | 2 | Access mode: 00 plain, 01 post-increment, 10 next address, 11 plain |
| iss_frame | input | 1 | Instruction restructures the stack frame |
| iss_frame_top | input | DW | New stack frame top |
| stk_bound | input | DW | Stack upper bound |
| cur_user | input | 1 | Current state is user |
| iss_priv | input | 1 | Instruction is a privileged operation |
| iss_ret | input | 1 | Instruction is a return |
| ret_user | input | 1 | Return target state is user |
| hi_prio_exc | input | 1 | A higher-priority exception coincides |
| exc_req | output | 1 | Registered request to the shared error vector |
| mem_suppress | output | 1 | Block the memory access this cycle |
| addr_wb_en | output | 1 | Allow the address register update this cycle |

## Verification
The frame compare is probed at equality, one below, and across bit 31, where a signed or strict compare would miss or mis-order the bound. A zero address in post-increment mode must still enable write-back; a design that tied write-back to the pointer check would lose the register update. Overlapping errors must give a single one-cycle request rather than a stretched one, and a coincident higher-priority exception must cancel the request without touching suppress. A return to user state running a privileged operation from supervisor state is checked separately from plain user-mode execution.

// File: rtl/etd_pkg.sv
package etd_pkg;
  localparam int unsigned AMODE_W = 2;

  typedef enum logic [AMODE_W-1:0] {
    AM_PLAIN   = 2'b00,
    AM_POSTINC = 2'b01,
    AM_NEXT    = 2'b10,
    AM_PLAIN2  = 2'b11
  } amode_e;

  typedef struct packed {
    logic range_e;
    logic ptr_e;
    logic frame_e;
    logic priv_e;
  } err_vec_t;

  function automatic logic amode_updates(input logic [AMODE_W-1:0] m);
    return (m == AM_POSTINC) || (m == AM_NEXT);
  endfunction
endpackage

// File: rtl/etd_ptr_unit.sv
module etd_ptr_unit #(
  parameter int unsigned DW = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic                        valid,
  input  logic                        mem,
  input  logic [DW-1:0]               addr,
  input  logic [etd_pkg::AMODE_W-1:0] amode,
  output logic                        ptr_err,
  output logic                        suppress,
  output logic                        wb_en
);
  localparam int unsigned NCH = DW / CHUNK;

  logic [NCH-1:0] chunk_nz;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_nz
      assign chunk_nz[g] = |addr[g*CHUNK +: CHUNK];
    end
  endgenerate

  logic addr_zero;
  logic access;

  always_comb begin
    addr_zero = ~|chunk_nz;
    access    = valid & mem;
    ptr_err   = access & addr_zero;
    suppress  = ptr_err;
    wb_en     = access & etd_pkg::amode_updates(amode);
  end
endmodule

// File: rtl/etd_cond_unit.sv
module etd_cond_unit #(
  parameter int unsigned DW = 32
) (
  input  logic          valid,
  input  logic          ovf,
  input  logic          frame,
  input  logic [DW-1:0] frame_top,
  input  logic [DW-1:0] bound,
  input  logic          cur_user,
  input  logic          priv,
  input  logic          ret,
  input  logic          ret_user,
  output logic          range_err,
  output logic          frame_err,
  output logic          priv_err
);
  logic top_ge_bound;
  logic lacks_priv;

  always_comb begin
    top_ge_bound = (frame_top >= bound);
    lacks_priv   = cur_user | (ret & ret_user);
    range_err    = valid & ovf;
    frame_err    = valid & frame & top_ge_bound;
    priv_err     = valid & priv & lacks_priv;
  end
endmodule

// File: rtl/etd_req_reg.sv
module etd_req_reg (
  input  logic              clk,
  input  logic              rst_n,
  input  etd_pkg::err_vec_t errs,
  input  logic              override,
  output logic              req
);
  logic any_err;

  always_comb any_err = |errs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= any_err & ~override;
  end
endmodule

// File: rtl/err_trap_detect.sv
module err_trap_detect #(
  parameter int unsigned DW = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  input  logic                        iss_ovf,
  input  logic                        iss_mem,
  input  logic [DW-1:0]               iss_addr,
  input  logic [etd_pkg::AMODE_W-1:0] iss_amode,
  input  logic                        iss_frame,
  input  logic [DW-1:0]               iss_frame_top,
  input  logic [DW-1:0]               stk_bound,
  input  logic                        cur_user,
  input  logic                        iss_priv,
  input  logic                        iss_ret,
  input  logic                        ret_user,
  input  logic                        hi_prio_exc,
  output logic                        exc_req,
  output logic                        mem_suppress,
  output logic                        addr_wb_en
);
  etd_pkg::err_vec_t errs;

  etd_ptr_unit #(.DW(DW), .CHUNK(CHUNK)) u_ptr (
    .valid    (iss_valid),
    .mem      (iss_mem),
    .addr     (iss_addr),
    .amode    (iss_amode),
    .ptr_err  (errs.ptr_e),
    .suppress (mem_suppress),
    .wb_en    (addr_wb_en)
  );

  etd_cond_unit #(.DW(DW)) u_cond (
    .valid     (iss_valid),
    .ovf       (iss_ovf),
    .frame     (iss_frame),
    .frame_top (iss_frame_top),
    .bound     (stk_bound),
    .cur_user  (cur_user),
    .priv      (iss_priv),
    .ret       (iss_ret),
    .ret_user  (ret_user),
    .range_err (errs.range_e),
    .frame_err (errs.frame_e),
    .priv_err  (errs.priv_e)
  );

  etd_req_reg u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .errs     (errs),
    .override (hi_prio_exc),
    .req      (exc_req)
  );
endmodule

// File: rtl/err_trap_detect_chk.sv
module err_trap_detect_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          iss_ovf,
  input logic          iss_mem,
  input logic [DW-1:0] iss_addr,
  input logic [1:0]    iss_amode,
  input logic          iss_frame,
  input logic [DW-1:0] iss_frame_top,
  input logic [DW-1:0] stk_bound,
  input logic          cur_user,
  input logic          iss_priv,
  input logic          hi_prio_exc,
  input logic          exc_req,
  input logic          mem_suppress,
  input logic          addr_wb_en
);
  // R2: overflow on a valid instruction yields a request next cycle
  a_r2_range_req: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ovf && !hi_prio_exc) |=> exc_req);

  // R3: a zero address on a valid access is blocked
  a_r3_null_block: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_mem && iss_addr == '0) |-> mem_suppress);

  // R4: post-increment keeps its write-back even when suppressed
  a_r4_wb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_suppress && iss_amode == 2'b01) |-> addr_wb_en);

  // R5: frame top at or above bound raises the request
  a_r5_frame_req: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_frame && iss_frame_top >= stk_bound && !hi_prio_exc) |=> exc_req);

  // R6: privileged op in user state raises the request
  a_r6_priv_user: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_priv && cur_user && !hi_prio_exc) |=> exc_req);

  // R8: higher-priority exception cancels the request
  a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
    hi_prio_exc |=> !exc_req);

  // R9: nothing happens without a valid instruction
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |=> !exc_req);

  a_r9_idle_comb: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (!mem_suppress && !addr_wb_en));
endmodule

bind err_trap_detect err_trap_detect_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .iss_valid     (iss_valid),
  .iss_ovf       (iss_ovf),
  .iss_mem       (iss_mem),
  .iss_addr      (iss_addr),
  .iss_amode     (iss_amode),
  .iss_frame     (iss_frame),
  .iss_frame_top (iss_frame_top),
  .stk_bound     (stk_bound),
  .cur_user      (cur_user),
  .iss_priv      (iss_priv),
  .hi_prio_exc   (hi_prio_exc),
  .exc_req       (exc_req),
  .mem_suppress  (mem_suppress),
  .addr_wb_en    (addr_wb_en)
);

// File: tb/test_err_trap_detect.sv
module test_err_trap_detect;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid, iss_ovf, iss_mem, iss_frame;
  logic [DW-1:0] iss_addr, iss_frame_top, stk_bound;
  logic [1:0]    iss_amode;
  logic          cur_user, iss_priv, iss_ret, ret_user, hi_prio_exc;
  logic          exc_req, mem_suppress, addr_wb_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  err_trap_detect #(.DW(DW)) i_err_trap_detect (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ovf(iss_ovf),
    .iss_mem(iss_mem), .iss_addr(iss_addr), .iss_amode(iss_amode),
    .iss_frame(iss_frame), .iss_frame_top(iss_frame_top), .stk_bound(stk_bound),
    .cur_user(cur_user), .iss_priv(iss_priv), .iss_ret(iss_ret),
    .ret_user(ret_user), .hi_prio_exc(hi_prio_exc), .exc_req(exc_req),
    .mem_suppress(mem_suppress), .addr_wb_en(addr_wb_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_ovf = 0; iss_mem = 0; iss_frame = 0;
    iss_addr = 32'h1000; iss_amode = 2'b00; iss_frame_top = 32'h10;
    stk_bound = 32'h100; cur_user = 0; iss_priv = 0; iss_ret = 0;
    ret_user = 0; hi_prio_exc = 0;
  endtask

  // inputs were set by the caller at a falling edge; check comb now,
  // request at the next falling edge, then one idle cycle for pulse width
  task automatic issue(input string req, input logic e_sup, input logic e_wb,
                       input logic e_req);
    #1;
    check({req, " suppress"}, mem_suppress, e_sup);
    check({req, " writeback"}, addr_wb_en, e_wb);
    @(negedge clk);
    check({req, " request"}, exc_req, e_req);
    idle();
    @(negedge clk);
    check({req, " request one cycle"}, exc_req, 1'b0);
  endtask

  task automatic t_reset();
    idle();
    repeat (2) @(negedge clk);
    check("R1 in reset", exc_req, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", exc_req, 1'b0);
  endtask

  task automatic t_range();
    iss_valid = 1; iss_ovf = 1;
    issue("R2 overflow", 0, 0, 1);
  endtask

  task automatic t_pointer();
    iss_valid = 1; iss_mem = 1; iss_addr = 0; iss_amode = 2'b00;
    issue("R3 null plain", 1, 0, 1);
    iss_valid = 1; iss_mem = 1; iss_addr = 32'h8000_0000;
    issue("R3 nonzero", 0, 0, 0);
  endtask

  task automatic t_writeback();
    iss_valid = 1; iss_mem = 1; iss_addr = 0; iss_amode = 2'b01;
    issue("R4 null postinc", 1, 1, 1);
    iss_valid = 1; iss_mem = 1; iss_addr = 0; iss_amode = 2'b10;
    issue("R4 null next", 1, 1, 1);
    iss_valid = 1; iss_mem = 1; iss_addr = 32'h44; iss_amode = 2'b10;
    issue("R4 next ok", 0, 1, 0);
    iss_valid = 1; iss_mem = 1; iss_addr = 32'h44; iss_amode = 2'b11;
    issue("R4 mode 11", 0, 0, 0);
  endtask

  task automatic t_frame();
    iss_valid = 1; iss_frame = 1; iss_frame_top = 32'h100; stk_bound = 32'h100;
    issue("R5 equal", 0, 0, 1);
    iss_valid = 1; iss_frame = 1; iss_frame_top = 32'hFF; stk_bound = 32'h100;
    issue("R5 one below", 0, 0, 0);
    iss_valid = 1; iss_frame = 1; iss_frame_top = 32'h8000_0000; stk_bound = 32'h7FFF_FFFF;
    issue("R5 unsigned", 0, 0, 1);
  endtask

  task automatic t_priv();
    iss_valid = 1; iss_priv = 1; cur_user = 1;
    issue("R6 user", 0, 0, 1);
    iss_valid = 1; iss_priv = 1; iss_ret = 1; ret_user = 1;
    issue("R6 return to user", 0, 0, 1);
    iss_valid = 1; iss_priv = 1; iss_ret = 1; ret_user = 0;
    issue("R6 supervisor", 0, 0, 0);
  endtask

  task automatic t_multi();
    iss_valid = 1; iss_ovf = 1; iss_mem = 1; iss_addr = 0;
    iss_frame = 1; iss_frame_top = 32'h200; iss_priv = 1; cur_user = 1;
    issue("R7 all four", 1, 0, 1);
  endtask

  task automatic t_override();
    iss_valid = 1; iss_mem = 1; iss_addr = 0; iss_amode = 2'b01; hi_prio_exc = 1;
    issue("R8 override", 1, 1, 0);
  endtask

  task automatic t_idle();
    iss_valid = 0; iss_ovf = 1; iss_mem = 1; iss_addr = 0; iss_amode = 2'b01;
    iss_frame = 1; iss_frame_top = 32'hFFFF_FFFF; iss_priv = 1; cur_user = 1;
    issue("R9 no valid", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_range();
    t_pointer();
    t_writeback();
    t_frame();
    t_priv();
    t_multi();
    t_override();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule